// File: doc/BRIEF.md
# Configuration Unlock Key Detector

This block sits on the card side of a shared configuration port and watches every byte the host writes to the address port. It unlocks only after the host writes a fixed 32-byte key. The key bytes are not stored. An 8-bit shift register generates each expected byte on the fly, starting from a seed value. The register shifts right and feeds the XOR of its two lowest bits back into the top bit.

Once the final key byte arrives, a sticky configuration-mode flag rises and a single-cycle completion pulse is issued. While the flag is up, further writes to the port have no effect on the detector. A separate wait-for-key command returns the block to the locked state and discards any partial progress.

The block has one clock domain. It uses an active-low asynchronous reset.

Top module: `ikd_top`

## Requirements
- R1: After reset `cfg_mode_o` and `key_done_o` are 0 and the next matching byte expected is the seed (default 0x6A).
- R2: Byte k+1 of the key is byte k shifted right by one with bit 7 set to bit1 XOR bit0 of byte k; with the default seed the first bytes are 0x6A, 0xB5, 0xDA, 0xED.
- R3: Both `cfg_mode_o` and `key_done_o` become 1 in the cycle after the edge that accepts the KEY_LEN-th consecutive matching write. After KEY_LEN-1 matching writes, `cfg_mode_o` is still 0.
- R4: `key_done_o` is high for exactly one cycle per completed key.
- R5: A locked-state write that differs from the expected byte and from the seed discards all progress, and the next expected byte is the seed.
- R6: A non-matching write equal to the seed counts as the first byte of a fresh key, so KEY_LEN-1 further key bytes complete it.
- R7: Two consecutive 0x00 writes in the middle of a key return the detector to the seed, and a full key sent afterwards completes.
- R8: While `cfg_mode_o` is 1, writes of any value leave `cfg_mode_o` at 1, raise no `key_done_o`, and leave the match progress at zero.
- R9: `lock_cmd_i` clears `cfg_mode_o` on the next edge and clears match progress. It takes priority over a write in the same cycle, and that write is dropped.
- R10: Cycles without `wr_en_i` between key bytes do not disturb the match progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the address port, one byte per high cycle |
| wr_data_i | input | 8 | Byte written to the address port |
| lock_cmd_i | input | 1 | Wait-for-key command; returns to the locked state |
| cfg_mode_o | output | 1 | Sticky flag, high while unlocked |
| key_done_o | output | 1 | One-cycle pulse when the key completes |

## Verification
The bench builds the block with its default parameters: KEY_LEN of 32 and seed 0x6A. This exercises the full key length, including the last-byte decode of the 6-bit progress counter and the whole 32-byte stretch of the generated sequence. With these values the seed does not reappear inside the key. That lets the bench use the seed as a restart byte in the middle of a key, and 0x00 as a byte that can never match.

// File: rtl/ikd_pkg.sv
package ikd_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    EXP_HOLD,
    EXP_STEP,
    EXP_SEED,
    EXP_SEED_STEP
  } exp_op_e;

  // right shift, bit7 <- bit1 ^ bit0
  function automatic byte_t key_step(byte_t v);
    return {v[1] ^ v[0], v[7:1]};
  endfunction
endpackage

// File: rtl/ikd_lfsr.sv
module ikd_lfsr
  import ikd_pkg::*;
#(
  parameter byte_t SEED = 8'h6A
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  exp_op_e op_i,
  output byte_t   exp_o
);
  localparam byte_t SEED_NEXT = key_step(SEED);

  byte_t exp_q, exp_d;

  always_comb begin
    unique case (op_i)
      EXP_STEP:      exp_d = key_step(exp_q);
      EXP_SEED:      exp_d = SEED;
      EXP_SEED_STEP: exp_d = SEED_NEXT;
      default:       exp_d = exp_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= SEED;
    else         exp_q <= exp_d;
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/ikd_count.sv
module ikd_count #(
  parameter int unsigned KEY_LEN = 32,
  localparam int unsigned CNT_W  = $clog2(KEY_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic one_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (one_i) cnt_q <= CNT_W'(1);
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  // next accepted match is the final one
  assign last_o = (cnt_q == CNT_W'(KEY_LEN - 1));
endmodule

// File: rtl/ikd_mode.sv
module ikd_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic cfg_mode_o,
  output logic done_o
);
  logic mode_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= set_i & ~clr_i;
      if (clr_i)      mode_q <= 1'b0;
      else if (set_i) mode_q <= 1'b1;
    end
  end

  assign cfg_mode_o = mode_q;
  assign done_o     = done_q;
endmodule

// File: rtl/ikd_top.sv
module ikd_top
  import ikd_pkg::*;
#(
  parameter int unsigned KEY_LEN = 32,
  parameter byte_t       SEED    = 8'h6A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       lock_cmd_i,
  output logic       cfg_mode_o,
  output logic       key_done_o
);
  byte_t   exp_byte;
  exp_op_e exp_op;
  logic    last_match, accept, hit, miss, restart, finish;
  logic    cnt_clr, cnt_one, cnt_inc;

  // lock command wins over a same-cycle write
  assign accept  = wr_en_i & ~cfg_mode_o & ~lock_cmd_i;
  assign hit     = accept & (wr_data_i == exp_byte);
  assign miss    = accept & ~hit;
  assign restart = miss & (wr_data_i == SEED);

  generate
    if (KEY_LEN == 1) begin : g_single
      assign finish = hit | restart;
    end else begin : g_multi
      assign finish = hit & last_match;
    end
  endgenerate

  always_comb begin
    exp_op = EXP_HOLD;
    if (lock_cmd_i || finish) exp_op = EXP_SEED;
    else if (hit)             exp_op = EXP_STEP;
    else if (restart)         exp_op = EXP_SEED_STEP;
    else if (miss)            exp_op = EXP_SEED;
  end

  assign cnt_clr = lock_cmd_i | finish | (miss & ~restart);
  assign cnt_one = restart;
  assign cnt_inc = hit;

  ikd_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (exp_op),
    .exp_o  (exp_byte)
  );

  ikd_count #(.KEY_LEN(KEY_LEN)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .one_i  (cnt_one),
    .inc_i  (cnt_inc),
    .last_o (last_match)
  );

  ikd_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (finish),
    .clr_i      (lock_cmd_i),
    .cfg_mode_o (cfg_mode_o),
    .done_o     (key_done_o)
  );
endmodule

// File: rtl/ikd_top_chk.sv
module ikd_top_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       lock_cmd_i,
  input logic       cfg_mode_o,
  input logic       key_done_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_done_o |=> !key_done_o); // R4
  AST_DONE_WITH_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_done_o |-> cfg_mode_o); // R3
  AST_MODE_RISE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> key_done_o); // R3
  AST_LOCK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_cmd_i |=> (!cfg_mode_o && !key_done_o)); // R9
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && !lock_cmd_i) |=> cfg_mode_o); // R8
  AST_NO_DONE_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_o |=> !key_done_o); // R8
  AST_DONE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !key_done_o); // R10
endmodule

bind ikd_top ikd_top_chk u_ikd_top_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .lock_cmd_i (lock_cmd_i),
  .cfg_mode_o (cfg_mode_o),
  .key_done_o (key_done_o)
);

// File: tb/ikd_top_bench.sv
module ikd_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_LEN    = 32;
  localparam logic [7:0] SEED = 8'h6A;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       lock_cmd_i = 1'b0;
  logic       cfg_mode_o, key_done_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] key [KEY_LEN];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ikd_top u_ikd_top (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .lock_cmd_i (lock_cmd_i),
    .cfg_mode_o (cfg_mode_o),
    .key_done_o (key_done_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the next negedge
  task automatic wr_byte(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic send_range(input int from, input int to);
    for (int i = from; i < to; i++) wr_byte(key[i]);
  endtask

  task automatic lock_pulse();
    lock_cmd_i = 1'b1;
    @(negedge clk_i);
    lock_cmd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cfg_mode after reset", cfg_mode_o, 1'b0);
    check("R1 key_done after reset", key_done_o, 1'b0);
  endtask

  task automatic t_full_key();
    check("R2 key head 0xB5", key[1] == 8'hB5, 1'b1);
    check("R2 key byte3 0xED", key[3] == 8'hED, 1'b1);
    send_range(0, KEY_LEN - 1);
    check("R3 locked after 31 bytes", cfg_mode_o, 1'b0);
    check("R2 no early done", key_done_o, 1'b0);
    wr_byte(key[KEY_LEN-1]);
    check("R3 cfg_mode on final byte", cfg_mode_o, 1'b1);
    check("R3 key_done on final byte", key_done_o, 1'b1);
    @(negedge clk_i);
    check("R4 key_done drops", key_done_o, 1'b0);
    check("R4 cfg_mode sticky", cfg_mode_o, 1'b1);
  endtask

  task automatic t_lock();
    lock_pulse();
    check("R9 lock clears cfg_mode", cfg_mode_o, 1'b0);
  endtask

  task automatic t_mismatch();
    send_range(0, 10);
    wr_byte(8'h55);
    send_range(1, KEY_LEN);
    check("R5 stale progress no unlock", cfg_mode_o, 1'b0);
    wr_byte(8'h55);
    send_range(0, KEY_LEN);
    check("R5 unlock after restart", cfg_mode_o, 1'b1);
    check("R5 done after restart", key_done_o, 1'b1);
    lock_pulse();
  endtask

  task automatic t_seed_restart();
    send_range(0, 5);
    wr_byte(SEED);
    send_range(1, KEY_LEN - 1);
    check("R6 one short after seed restart", cfg_mode_o, 1'b0);
    wr_byte(key[KEY_LEN-1]);
    check("R6 seed restart counts as first", cfg_mode_o, 1'b1);
    check("R6 done pulse", key_done_o, 1'b1);
    lock_pulse();
  endtask

  task automatic t_zero_resync();
    send_range(0, 7);
    wr_byte(8'h00);
    wr_byte(8'h00);
    send_range(0, KEY_LEN - 1);
    check("R7 not yet after resync", cfg_mode_o, 1'b0);
    wr_byte(key[KEY_LEN-1]);
    check("R7 unlock after zero pair", cfg_mode_o, 1'b1);
    lock_pulse();
  endtask

  task automatic t_ignore();
    send_range(0, KEY_LEN);
    @(negedge clk_i);
    wr_byte(8'h00);
    wr_byte(8'hFF);
    send_range(0, KEY_LEN);
    check("R8 cfg_mode held", cfg_mode_o, 1'b1);
    check("R8 no done in cfg_mode", key_done_o, 1'b0);
    send_range(0, 3);
    lock_pulse();
    // prior writes left no progress: full key needed
    send_range(0, KEY_LEN - 1);
    check("R8 progress untouched", cfg_mode_o, 1'b0);
    wr_byte(key[KEY_LEN-1]);
    check("R8 fresh key unlocks", cfg_mode_o, 1'b1);
    lock_pulse();
  endtask

  task automatic t_lock_priority();
    send_range(0, KEY_LEN - 1);
    lock_cmd_i = 1'b1;
    wr_byte(key[KEY_LEN-1]);
    lock_cmd_i = 1'b0;
    check("R9 lock beats final write", cfg_mode_o, 1'b0);
    check("R9 no done with lock", key_done_o, 1'b0);
    send_range(0, 20);
    lock_pulse();
    send_range(20, KEY_LEN);
    check("R9 lock clears progress", cfg_mode_o, 1'b0);
    wr_byte(8'h00);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < KEY_LEN; i++) begin
      wr_byte(key[i]);
      repeat (i % 3) @(negedge clk_i);
      if (i == KEY_LEN - 2) check("R10 locked before last", cfg_mode_o, 1'b0);
    end
    check("R10 unlock with idle gaps", cfg_mode_o, 1'b1);
    lock_pulse();
  endtask

  initial begin
    key[0] = SEED;
    for (int i = 1; i < KEY_LEN; i++)
      key[i] = {key[i-1][1] ^ key[i-1][0], key[i-1][7:1]};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_full_key();
    t_lock();
    t_mismatch();
    t_seed_restart();
    t_zero_resync();
    t_ignore();
    t_lock_priority();
    t_gaps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule